// File: doc/BRIEF.md
# Issue Timestamp Ordering Checker

This block watches the issue stage of an out-of-order core and confirms that every instruction which reads a renamed register was issued no earlier than its producer's result could exist. A free-running issue clock stamps every event. When a producer issues, the block stores, under the producer's physical destination tag, the cycle in which its result becomes ready. For a fixed-latency producer that cycle is the issue time plus the latency it reports. A producer with variable latency, such as a load, stays pending until its writeback, and its ready time is the writeback cycle.

When a consumer issues, it presents up to two source tags. For each enabled source whose producer is still tracked, the block subtracts the producer's ready time from the consumer's issue time, modulo the clock width, and reads the sign of the result. A negative difference, or a producer still waiting for writeback, raises that source's own error bit one cycle later. When a producer's result becomes architecturally available, the retire port clears its tag, and later reads of that tag are not checked. The block catches only premature issue. A consumer that names the wrong tag is not detected.

Top module: `issue_order_chk`

## Requirements
- R1: After reset every tag is untracked and `early_err` is all zero, so a consumer issuing right after reset raises no error.
- R2: A fixed-latency producer with latency L (4 bits, 0 to 15) issued in cycle T is ready at T+L. A consumer reading its tag in a cycle T+k with k < L raises the error bit of that source.
- R3: A consumer at T+k with k >= L raises no error. The boundary k = L is legal for every L, including L = 15.
- R4: `early_err[i]` is a one-cycle pulse in the cycle after the consumer's issue cycle. It can be set only when `cons_issue` and `cons_src_en[i]` were both high. A disabled source never errs, whatever its tag.
- R5: Each source is checked independently, and source i's tag sits in bits [i*TAG_W +: TAG_W] of `cons_src_tag`. In the same cycle one source can err while the other does not.
- R6: A producer issued with `prod_varlat` high is pending until `wb_valid` names its tag. Any consumer reading it before the writeback cycle, or in the writeback cycle itself, errs. Consumers from the cycle after writeback onward pass.
- R7: `ret_valid` stops tracking of `ret_tag` from the next cycle on. Consumers of that tag then raise no error until a new producer issues on it.
- R8: If a producer issues and a retire names the same tag in the same cycle, the new producer is recorded and the retire has no effect.
- R9: A consumer is checked against the table as it stood before the current cycle's updates. If a producer issues on the same tag in the same cycle, the consumer sees the earlier entry.
- R10: Time differences are taken modulo 2^13 and read as signed. Wraparound of the 13-bit issue clock causes no false and no missed error while producer and consumer are less than 4096 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prod_issue | input | 1 | A producer issues this cycle |
| prod_tag | input | TAG_W | Physical destination tag of the producer |
| prod_lat | input | LAT_W | Fixed execution latency of the producer |
| prod_varlat | input | 1 | Producer latency is variable; completion comes from writeback |
| wb_valid | input | 1 | Writeback of a variable-latency producer |
| wb_tag | input | TAG_W | Tag being written back |
| ret_valid | input | 1 | A producer's result is now architecturally available |
| ret_tag | input | TAG_W | Tag to stop tracking |
| cons_issue | input | 1 | A consumer issues this cycle |
| cons_src_en | input | NSRC | Per-source enable for the consumer |
| cons_src_tag | input | NSRC*TAG_W | Source tags, source i at bits [i*TAG_W +: TAG_W] |
| early_err | output | NSRC | Per-source premature-issue flag, one cycle after the consumer |

## Verification
The bench builds the block with its default parameters: 64 tags, two sources, a 13-bit clock and 4-bit latencies. The maximum latency of 15 can therefore be tested at its exact boundary. A single long test repeats producer and consumer pairs for more than 8192 cycles, so the issue clock wraps during the run and ready times that straddle the wrap are compared. With two sources, one consumer can show one source failing while the other passes in the same cycle.

// File: rtl/issue_order_pkg.sv
package issue_order_pkg;
    localparam int unsigned IOC_TS_W  = 13;
    localparam int unsigned IOC_LAT_W = 4;

    // outcome of checking one consumer source
    typedef enum logic [1:0] {
        SRC_SKIP    = 2'd0,
        SRC_OK      = 2'd1,
        SRC_EARLY   = 2'd2,
        SRC_PENDING = 2'd3
    } src_verdict_e;
endpackage

// File: rtl/iot_clock.sv
module iot_clock #(
    parameter int unsigned TS_W = issue_order_pkg::IOC_TS_W
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [TS_W-1:0] now
);
    typedef struct packed {
        logic [TS_W-1:0] cnt;
    } clk_state_t;

    clk_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign now = st_q.cnt;
endmodule

// File: rtl/iot_ready_table.sv
module iot_ready_table #(
    parameter int unsigned TAG_W = 6,
    parameter int unsigned NSRC  = 2,
    parameter int unsigned TS_W  = issue_order_pkg::IOC_TS_W,
    parameter int unsigned LAT_W = issue_order_pkg::IOC_LAT_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [TS_W-1:0]       now,
    input  logic                  prod_issue,
    input  logic [TAG_W-1:0]      prod_tag,
    input  logic [LAT_W-1:0]      prod_lat,
    input  logic                  prod_varlat,
    input  logic                  wb_valid,
    input  logic [TAG_W-1:0]      wb_tag,
    input  logic                  ret_valid,
    input  logic [TAG_W-1:0]      ret_tag,
    input  logic [NSRC*TAG_W-1:0] rd_tag,
    output logic [NSRC-1:0]       rd_vld,
    output logic [NSRC-1:0]       rd_pend,
    output logic [NSRC*TS_W-1:0]  rd_rdy
);
    localparam int unsigned DEPTH = 1 << TAG_W;

    typedef struct packed {
        logic            vld;
        logic            pend;
        logic [TS_W-1:0] rdy;
    } entry_t;

    entry_t tab_d [DEPTH];
    entry_t tab_q [DEPTH];

    logic [TS_W-1:0] fixed_rdy;
    assign fixed_rdy = now + TS_W'(prod_lat);

    always_comb begin
        for (int i = 0; i < DEPTH; i++) tab_d[i] = tab_q[i];
        // retire first, then writeback, then a new producer, so a same-cycle issue wins
        if (ret_valid) begin
            tab_d[ret_tag].vld  = 1'b0;
            tab_d[ret_tag].pend = 1'b0;
        end
        if (wb_valid && tab_d[wb_tag].vld && tab_d[wb_tag].pend) begin
            tab_d[wb_tag].pend = 1'b0;
            tab_d[wb_tag].rdy  = now;
        end
        if (prod_issue) begin
            tab_d[prod_tag].vld  = 1'b1;
            tab_d[prod_tag].pend = prod_varlat;
            tab_d[prod_tag].rdy  = prod_varlat ? now : fixed_rdy;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) tab_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) tab_q[i] <= tab_d[i];
        end
    end

    for (genvar s = 0; s < NSRC; s++) begin : g_rd
        logic [TAG_W-1:0] t;
        assign t                       = rd_tag[s*TAG_W +: TAG_W];
        assign rd_vld[s]               = tab_q[t].vld;
        assign rd_pend[s]              = tab_q[t].pend;
        assign rd_rdy[s*TS_W +: TS_W]  = tab_q[t].rdy;
    end
endmodule

// File: rtl/iot_src_cmp.sv
module iot_src_cmp
    import issue_order_pkg::*;
#(
    parameter int unsigned TS_W = IOC_TS_W
) (
    input  logic            cons_issue,
    input  logic            src_en,
    input  logic [TS_W-1:0] now,
    input  logic            ent_vld,
    input  logic            ent_pend,
    input  logic [TS_W-1:0] ent_rdy,
    output src_verdict_e    verdict,
    output logic            early
);
    logic [TS_W-1:0] diff;
    assign diff = now - ent_rdy;

    always_comb begin
        if (!(cons_issue && src_en && ent_vld)) verdict = SRC_SKIP;
        else if (ent_pend)                      verdict = SRC_PENDING;
        else if (diff[TS_W-1])                  verdict = SRC_EARLY;
        else                                    verdict = SRC_OK;
    end

    assign early = (verdict == SRC_EARLY) || (verdict == SRC_PENDING);
endmodule

// File: rtl/issue_order_chk.sv
module issue_order_chk
    import issue_order_pkg::*;
#(
    parameter int unsigned TAG_W = 6,
    parameter int unsigned NSRC  = 2,
    parameter int unsigned TS_W  = IOC_TS_W,
    parameter int unsigned LAT_W = IOC_LAT_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  prod_issue,
    input  logic [TAG_W-1:0]      prod_tag,
    input  logic [LAT_W-1:0]      prod_lat,
    input  logic                  prod_varlat,
    input  logic                  wb_valid,
    input  logic [TAG_W-1:0]      wb_tag,
    input  logic                  ret_valid,
    input  logic [TAG_W-1:0]      ret_tag,
    input  logic                  cons_issue,
    input  logic [NSRC-1:0]       cons_src_en,
    input  logic [NSRC*TAG_W-1:0] cons_src_tag,
    output logic [NSRC-1:0]       early_err
);
    typedef struct packed {
        logic [NSRC-1:0] err;
    } out_state_t;

    logic [TS_W-1:0]      now;
    logic [NSRC-1:0]      rd_vld, rd_pend, src_early;
    logic [NSRC*TS_W-1:0] rd_rdy;
    out_state_t           st_d, st_q;

    iot_clock #(.TS_W(TS_W)) clock_i (
        .clk(clk), .rst_n(rst_n), .now(now)
    );

    iot_ready_table #(
        .TAG_W(TAG_W), .NSRC(NSRC), .TS_W(TS_W), .LAT_W(LAT_W)
    ) table_i (
        .clk(clk), .rst_n(rst_n), .now(now),
        .prod_issue(prod_issue), .prod_tag(prod_tag), .prod_lat(prod_lat),
        .prod_varlat(prod_varlat),
        .wb_valid(wb_valid), .wb_tag(wb_tag),
        .ret_valid(ret_valid), .ret_tag(ret_tag),
        .rd_tag(cons_src_tag),
        .rd_vld(rd_vld), .rd_pend(rd_pend), .rd_rdy(rd_rdy)
    );

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        src_verdict_e verdict;
        iot_src_cmp #(.TS_W(TS_W)) cmp_i (
            .cons_issue(cons_issue),
            .src_en(cons_src_en[s]),
            .now(now),
            .ent_vld(rd_vld[s]),
            .ent_pend(rd_pend[s]),
            .ent_rdy(rd_rdy[s*TS_W +: TS_W]),
            .verdict(verdict),
            .early(src_early[s])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.err = src_early;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign early_err = st_q.err;
endmodule

// File: rtl/issue_order_chk_sva.sv
module issue_order_chk_sva #(
    parameter int unsigned TAG_W = 6,
    parameter int unsigned NSRC  = 2,
    parameter int unsigned LAT_W = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  prod_issue,
    input logic [TAG_W-1:0]      prod_tag,
    input logic [LAT_W-1:0]      prod_lat,
    input logic                  prod_varlat,
    input logic                  ret_valid,
    input logic [TAG_W-1:0]      ret_tag,
    input logic                  cons_issue,
    input logic [NSRC-1:0]       cons_src_en,
    input logic [NSRC*TAG_W-1:0] cons_src_tag,
    input logic [NSRC-1:0]       early_err
);
    logic [TAG_W-1:0] tag0;
    assign tag0 = cons_src_tag[TAG_W-1:0];

    // R4: an error bit only follows an enabled consumer source
    for (genvar s = 0; s < NSRC; s++) begin : g_cause
        p_err_has_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
            early_err[s] |-> $past(cons_issue && cons_src_en[s]));
    end

    // R2: fixed producer with latency >= 2, consumer one cycle later
    p_short_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cons_issue && cons_src_en[0] && $past(prod_issue) && !$past(prod_varlat)
         && ($past(prod_lat) >= 2) && ($past(prod_tag) == tag0)) |=> early_err[0]);

    // R6: variable-latency producer still pending one cycle later
    p_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cons_issue && cons_src_en[0] && $past(prod_issue) && $past(prod_varlat)
         && ($past(prod_tag) == tag0)) |=> early_err[0]);

    // R7: a tag retired last cycle (no same-cycle reissue) is not checked
    p_retired_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ret_valid) && ($past(ret_tag) == tag0)
         && !($past(prod_issue) && ($past(prod_tag) == $past(ret_tag)))) |=> !early_err[0]);

    // R1: no error right after reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (early_err == '0));
endmodule

bind issue_order_chk issue_order_chk_sva #(
    .TAG_W(TAG_W), .NSRC(NSRC), .LAT_W(LAT_W)
) sva_i (
    .clk(clk), .rst_n(rst_n),
    .prod_issue(prod_issue), .prod_tag(prod_tag), .prod_lat(prod_lat),
    .prod_varlat(prod_varlat),
    .ret_valid(ret_valid), .ret_tag(ret_tag),
    .cons_issue(cons_issue), .cons_src_en(cons_src_en),
    .cons_src_tag(cons_src_tag), .early_err(early_err)
);

// File: tb/issue_order_chk_tb_top.sv
module issue_order_chk_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TAG_W = 6;
    localparam int NSRC  = 2;
    localparam int LAT_W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic prod_issue = 1'b0, prod_varlat = 1'b0;
    logic [TAG_W-1:0] prod_tag = '0, wb_tag = '0, ret_tag = '0;
    logic [LAT_W-1:0] prod_lat = '0;
    logic wb_valid = 1'b0, ret_valid = 1'b0, cons_issue = 1'b0;
    logic [NSRC-1:0] cons_src_en = '0;
    logic [NSRC*TAG_W-1:0] cons_src_tag = '0;
    logic [NSRC-1:0] early_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    issue_order_chk dut_i (
        .clk(clk), .rst_n(rst_n),
        .prod_issue(prod_issue), .prod_tag(prod_tag), .prod_lat(prod_lat),
        .prod_varlat(prod_varlat),
        .wb_valid(wb_valid), .wb_tag(wb_tag),
        .ret_valid(ret_valid), .ret_tag(ret_tag),
        .cons_issue(cons_issue), .cons_src_en(cons_src_en),
        .cons_src_tag(cons_src_tag), .early_err(early_err)
    );

    task automatic check(string req, logic [NSRC-1:0] exp);
        n_chk++;
        if (early_err !== exp) begin
            n_bad++;
            $display("FAIL %s: early_err=%b expected=%b at %0t", req, early_err, exp, $time);
        end
    endtask

    task automatic clear_in();
        prod_issue = 0; prod_varlat = 0; wb_valid = 0; ret_valid = 0;
        cons_issue = 0; cons_src_en = '0;
    endtask

    // one cycle: inputs set at a negedge, outputs readable at the next negedge
    task automatic step();
        @(negedge clk);
        clear_in();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic set_prod(int tag, int lat, bit v);
        prod_issue = 1; prod_tag = TAG_W'(tag); prod_lat = LAT_W'(lat); prod_varlat = v;
    endtask

    task automatic set_cons(bit e0, int t0, bit e1, int t1);
        cons_issue = 1; cons_src_en = {e1, e0};
        cons_src_tag = {TAG_W'(t1), TAG_W'(t0)};
    endtask

    task automatic t_reset();
        set_cons(1, 9, 1, 10); step();
        check("R1 consumer right after reset", 2'b00);
    endtask

    // producer at gap 0, consumer at gap k
    task automatic gap_case(int tag, int lat, int k, string req, bit exp);
        set_prod(tag, lat, 0); step();
        idle(k - 1);
        set_cons(1, tag, 0, 0); step();
        check(req, {1'b0, exp});
        ret_valid = 1; ret_tag = TAG_W'(tag); step();
    endtask

    task automatic t_fixed();
        gap_case(3, 3, 1, "R2 lat3 gap1", 1);
        gap_case(3, 3, 2, "R2 lat3 gap2", 1);
        gap_case(3, 3, 3, "R3 lat3 gap3 boundary", 0);
        gap_case(3, 3, 5, "R3 lat3 gap5", 0);
        gap_case(4, 15, 14, "R2 lat15 gap14", 1);
        gap_case(4, 15, 15, "R3 lat15 gap15 boundary", 0);
        gap_case(5, 0, 1, "R3 lat0 gap1", 0);
    endtask

    task automatic t_pulse_and_enable();
        set_prod(7, 6, 0); step();
        set_cons(0, 7, 0, 7); step();
        check("R4 disabled sources never err", 2'b00);
        set_cons(1, 7, 1, 7); step();
        check("R4 both enabled early", 2'b11);
        step();
        check("R4 error is a single-cycle pulse", 2'b00);
        ret_valid = 1; ret_tag = 7; step();
    endtask

    task automatic t_two_src();
        set_prod(12, 2, 0); step();
        set_prod(13, 9, 0); step();
        idle(2);
        set_cons(1, 12, 1, 13); step();   // gap 4 vs lat2, gap 3 vs lat9
        check("R5 src0 ok src1 early", 2'b10);
        set_cons(1, 13, 1, 12); step();
        check("R5 swapped sources", 2'b01);
        ret_valid = 1; ret_tag = 12; step();
        ret_valid = 1; ret_tag = 13; step();
    endtask

    task automatic t_varlat();
        set_prod(20, 0, 1); step();
        idle(20);
        set_cons(1, 20, 0, 0); step();
        check("R6 pending after long wait", 2'b01);
        wb_valid = 1; wb_tag = 20; set_cons(1, 20, 0, 0); step();
        check("R6 consumer in writeback cycle", 2'b01);
        set_cons(1, 20, 0, 0); step();
        check("R6 consumer after writeback", 2'b00);
        ret_valid = 1; ret_tag = 20; step();
    endtask

    task automatic t_retire();
        set_prod(30, 15, 0); step();
        ret_valid = 1; ret_tag = 30; step();
        set_cons(1, 30, 1, 30); step();
        check("R7 retired tag not checked", 2'b00);
        // R8: issue and retire on the same tag in one cycle
        set_prod(31, 15, 0); ret_valid = 1; ret_tag = 31; step();
        set_cons(1, 31, 0, 0); step();
        check("R8 same-cycle issue beats retire", 2'b01);
        ret_valid = 1; ret_tag = 31; step();
    endtask

    task automatic t_same_cycle();
        set_prod(40, 15, 0); set_cons(1, 40, 0, 0); step();
        check("R9 consumer sees old untracked entry", 2'b00);
        set_cons(1, 40, 0, 0); step();
        check("R9 new entry applies next cycle", 2'b01);
        ret_valid = 1; ret_tag = 40; step();
    endtask

    task automatic t_wrap();
        int bad_before;
        bad_before = n_bad;
        for (int it = 0; it < 1100; it++) begin
            set_prod(50, 7, 0); step();
            idle(5);
            set_cons(1, 50, 0, 0); step();
            check("R10 gap6 lat7 across wrap", 2'b01);
            set_cons(1, 50, 0, 0); step();
            check("R10 gap7 lat7 across wrap", 2'b00);
        end
        if (n_bad != bad_before) $display("R10 wrap sweep had mismatches");
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run incomplete, actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fixed();
        t_pulse_and_enable();
        t_two_src();
        t_varlat();
        t_retire();
        t_same_cycle();
        t_wrap();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule